// File: doc/BRIEF.md
# Function scope detector

This block watches a processor's instruction address and register write-back traffic to tell when one chosen function is running. It keeps its own copy of the stack pointer by snooping every write-back to general register 29, on either of two write ports. When the instruction address reaches the function's start address while nothing is being tracked, it raises a one-cycle entry pulse and records the stack pointer at that moment. That recorded value identifies the invocation's activation record.

Because the stack grows downward, the tracked invocation ends when the live stack pointer first drops by at least a full frame below the recorded value and later climbs back to or above it. At that point the block raises a one-cycle exit pulse. Any call of the same function that begins while the outer invocation is tracked runs deeper on the stack. Such a call is ignored, so recursion does not disturb the tracked call. A level output marks the tracked interval, and a second level output marks instruction addresses inside the prologue bytes of the function while in scope. A run-time checking unit consumes these outputs as its local-trace boundaries.

Top module: `fscope_tracker`

## Requirements
- R1: After a synchronous active-low reset, `scope_o`, `exit_o` and `frame_sp_o` are 0 and the internal stack-pointer copy is 0, so an entry right after reset records 0.
- R2: `entry_o` is 1 in any cycle where `pc_i` equals `FUNC_ADDR` (default 32'h8000_0378) and `scope_o` is 0. It is 0 in every other cycle, including the cycle where `pc_i` is `FUNC_ADDR` while `scope_o` is 1.
- R3: `scope_o` rises in the cycle after an `entry_o` pulse. From that cycle `frame_sp_o` holds the stack-pointer copy as it stood during the entry cycle, and it stays unchanged while `scope_o` is high.
- R4: The stack-pointer copy takes `wbN_data` at the clock edge ending a cycle in which `wbN_en` is 1 and `wbN_idx` is 29. If both ports do this in the same cycle, port 1 (`wb1_*`) wins. A write with a different index, or with enable 0, leaves the copy unchanged.
- R5: `prologue_o` is 1 exactly when `scope_o` is 1 and `pc_i - FUNC_ADDR` (unsigned) is below `PROLOGUE_BYTES` (default 12).
- R6: The block becomes armed in a cycle after entry where the copy plus `FRAME_BYTES` (default 32) is at most `frame_sp_o`. This takes effect at the following edge. Once armed, `exit_o` is 1 in the first cycle where the copy is at or above `frame_sp_o`, and `scope_o` falls in the cycle after. A rise back to the frame without a full-frame drop before it gives no exit.
- R7: A re-entry at `FUNC_ADDR` while in scope gives no `entry_o` and leaves `frame_sp_o` unchanged. The inner call's return to a stack pointer still below the recorded frame gives no `exit_o`.
- R8: An invocation whose stack pointer never returns to its recorded frame keeps `scope_o` at 1 and never gives `exit_o`, until reset.
- R9: `entry_o` and `exit_o` are never 1 in the same cycle, and `exit_o` and `prologue_o` are only 1 while `scope_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pc_i | input | ADDR_W | Address of the instruction in the observed stage |
| wb0_en | input | 1 | Write-back port 0 valid |
| wb0_idx | input | 5 | Write-back port 0 register index |
| wb0_data | input | XLEN | Write-back port 0 data |
| wb1_en | input | 1 | Write-back port 1 valid (wins on conflict) |
| wb1_idx | input | 5 | Write-back port 1 register index |
| wb1_data | input | XLEN | Write-back port 1 data |
| scope_o | output | 1 | Tracked invocation active |
| entry_o | output | 1 | One-cycle pulse on the invocation's first instruction |
| exit_o | output | 1 | One-cycle pulse when the frame is popped |
| prologue_o | output | 1 | In scope and address inside the prologue bytes |
| frame_sp_o | output | XLEN | Stack pointer recorded at entry |

## Verification
`entry_o` and `prologue_o` follow `pc_i` in the same cycle. `scope_o` and `frame_sp_o` change one edge after the entry cycle. A stack-pointer write shows up in `exit_o` only in the cycle after the write, because the copy is registered. Arming takes one more edge after the drop is in the copy. The bench drives inputs on the falling edge and samples in the middle of the low phase. Each expectation is checked in the cycle these counts give. The frame rise is placed at least one cycle after the frame drop, and the bench looks for the exit pulse exactly one cycle after the rise.

// File: rtl/fscope_pkg.sv
// Shared constants and types for the function scope detector.
// Assumes a register file with 32 entries and the stack pointer in entry 29.
package fscope_pkg;
    localparam int unsigned GPR_IDX_W = 5;
    localparam logic [GPR_IDX_W-1:0] STACK_REG = 5'd29;

    typedef enum logic {
        TRK_IDLE   = 1'b0,
        TRK_ACTIVE = 1'b1
    } trk_state_e;
endpackage

// File: rtl/fscope_sp_shadow.sv
// Shadow copy of the stack pointer, rebuilt from register write-back ports.
// Assumes ports are numbered by priority: a higher-numbered port overrides
// a lower one when both write the stack register in the same cycle.
module fscope_sp_shadow #(
    parameter int unsigned XLEN      = 32,
    parameter int unsigned NUM_PORTS = 2,
    parameter int unsigned IDX_W     = 5,
    parameter logic [IDX_W-1:0] SP_IDX = 5'd29
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_PORTS-1:0]            wr_en,
    input  logic [NUM_PORTS-1:0][IDX_W-1:0] wr_idx,
    input  logic [NUM_PORTS-1:0][XLEN-1:0]  wr_data,
    output logic [XLEN-1:0]                 sp_q
);
    logic [NUM_PORTS-1:0] hit;
    logic [XLEN-1:0]      sp_d;

    // One comparator per write port for the stack register index.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_hit
        assign hit[p] = wr_en[p] && (wr_idx[p] == SP_IDX);
    end

    // Pick the next value; later ports overwrite earlier ones.
    always_comb begin
        sp_d = sp_q;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (hit[p]) sp_d = wr_data[p];
        end
    end

    // Hold the shadow stack pointer; cleared to zero by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) sp_q <= '0;
        else        sp_q <= sp_d;
    end
endmodule

// File: rtl/fscope_pc_decode.sv
// Instruction-address decode for the watched function.
// Flags the exact start address and the prologue byte window after it.
// Assumes the prologue is contiguous from the start address.
module fscope_pc_decode #(
    parameter int unsigned ADDR_W = 32,
    parameter logic [ADDR_W-1:0] FUNC_ADDR = 32'h8000_0378,
    parameter int unsigned PROLOGUE_BYTES = 12
) (
    input  logic [ADDR_W-1:0] pc,
    output logic              start_hit,
    output logic              in_window
);
    localparam logic [ADDR_W-1:0] PRO_LEN = ADDR_W'(PROLOGUE_BYTES);

    logic [ADDR_W-1:0] offset;

    // Unsigned distance from the start; wraps large below the start.
    assign offset    = pc - FUNC_ADDR;
    assign start_hit = (pc == FUNC_ADDR);
    assign in_window = (offset < PRO_LEN);
endmodule

// File: rtl/fscope_ctrl.sv
// Scope controller: starts tracking on an address match while idle,
// records the stack pointer as the frame identity, arms once the stack
// has dropped a full frame below it, and ends tracking when the stack
// pointer climbs back to the frame. Assumes a downward-growing stack.
module fscope_ctrl #(
    parameter int unsigned XLEN        = 32,
    parameter int unsigned FRAME_BYTES = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_hit,
    input  logic            in_window,
    input  logic [XLEN-1:0] sp_live,
    output logic            scope_o,
    output logic            entry_o,
    output logic            exit_o,
    output logic            prologue_o,
    output logic [XLEN-1:0] frame_o
);
    import fscope_pkg::*;

    localparam logic [XLEN:0] FRAME_EXT = (XLEN+1)'(FRAME_BYTES);

    trk_state_e      state_q, state_d;
    logic [XLEN-1:0] frame_q;
    logic            armed_q;
    logic            active;
    logic            deep_enough;
    logic            popped;

    // Decode of current state and stack position relative to the frame.
    assign active      = (state_q == TRK_ACTIVE);
    assign deep_enough = ({1'b0, sp_live} + FRAME_EXT) <= {1'b0, frame_q};
    assign popped      = (sp_live >= frame_q);

    assign entry_o    = !active && start_hit;
    assign exit_o     = active && armed_q && popped;
    assign prologue_o = active && in_window;
    assign scope_o    = active;
    assign frame_o    = frame_q;

    // Next tracking state.
    always_comb begin
        state_d = state_q;
        if (entry_o)     state_d = TRK_ACTIVE;
        else if (exit_o) state_d = TRK_IDLE;
    end

    // State, recorded frame and arming flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TRK_IDLE;
            frame_q <= '0;
            armed_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (entry_o) begin
                frame_q <= sp_live;
                armed_q <= 1'b0;
            end else if (active && deep_enough) begin
                armed_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/fscope_tracker.sv
// Top of the function scope detector. Joins the two write-back ports
// into the stack-pointer shadow, decodes the instruction address and
// runs the scope controller. Port 1 has priority on the stack register.
module fscope_tracker #(
    parameter int unsigned ADDR_W         = 32,
    parameter int unsigned XLEN           = 32,
    parameter logic [ADDR_W-1:0] FUNC_ADDR = 32'h8000_0378,
    parameter int unsigned FRAME_BYTES    = 32,
    parameter int unsigned PROLOGUE_BYTES = 12
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [ADDR_W-1:0]               pc_i,
    input  logic                            wb0_en,
    input  logic [fscope_pkg::GPR_IDX_W-1:0] wb0_idx,
    input  logic [XLEN-1:0]                 wb0_data,
    input  logic                            wb1_en,
    input  logic [fscope_pkg::GPR_IDX_W-1:0] wb1_idx,
    input  logic [XLEN-1:0]                 wb1_data,
    output logic                            scope_o,
    output logic                            entry_o,
    output logic                            exit_o,
    output logic                            prologue_o,
    output logic [XLEN-1:0]                 frame_sp_o
);
    import fscope_pkg::*;

    localparam int unsigned NUM_WB = 2;

    logic [NUM_WB-1:0]                wr_en;
    logic [NUM_WB-1:0][GPR_IDX_W-1:0] wr_idx;
    logic [NUM_WB-1:0][XLEN-1:0]      wr_data;
    logic [XLEN-1:0]                  sp_live;
    logic                             start_hit;
    logic                             in_window;

    // Port 1 sits at the higher index so it wins on a conflict.
    assign wr_en   = {wb1_en, wb0_en};
    assign wr_idx  = {wb1_idx, wb0_idx};
    assign wr_data = {wb1_data, wb0_data};

    fscope_sp_shadow #(
        .XLEN(XLEN), .NUM_PORTS(NUM_WB), .IDX_W(GPR_IDX_W), .SP_IDX(STACK_REG)
    ) u_sp (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .sp_q(sp_live)
    );

    fscope_pc_decode #(
        .ADDR_W(ADDR_W), .FUNC_ADDR(FUNC_ADDR), .PROLOGUE_BYTES(PROLOGUE_BYTES)
    ) u_pc (
        .pc(pc_i), .start_hit(start_hit), .in_window(in_window)
    );

    fscope_ctrl #(
        .XLEN(XLEN), .FRAME_BYTES(FRAME_BYTES)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .start_hit(start_hit), .in_window(in_window), .sp_live(sp_live),
        .scope_o(scope_o), .entry_o(entry_o), .exit_o(exit_o),
        .prologue_o(prologue_o), .frame_o(frame_sp_o)
    );
endmodule

// File: rtl/fscope_tracker_chk.sv
// Property checker for the function scope detector, bound to the top.
module fscope_tracker_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned XLEN   = 32,
    parameter logic [ADDR_W-1:0] FUNC_ADDR = 32'h8000_0378
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] pc_i,
    input logic              scope_o,
    input logic              entry_o,
    input logic              exit_o,
    input logic              prologue_o,
    input logic [XLEN-1:0]   frame_sp_o
);
    // R2
    entry_needs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        entry_o |-> !scope_o);
    // R7
    reentry_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scope_o && pc_i == FUNC_ADDR) |-> !entry_o);
    // R3
    entry_opens_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        entry_o |=> scope_o);
    // R3
    scope_rise_from_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scope_o) |-> $past(entry_o));
    // R3
    frame_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scope_o && $past(scope_o)) |-> $stable(frame_sp_o));
    // R6
    exit_closes_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exit_o |=> !scope_o);
    // R9
    no_entry_exit_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({entry_o, exit_o}) <= 1);
    // R9
    exit_in_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exit_o |-> scope_o);
    // R9
    prologue_in_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prologue_o |-> scope_o);
endmodule

bind fscope_tracker fscope_tracker_chk #(
    .ADDR_W(ADDR_W), .XLEN(XLEN), .FUNC_ADDR(FUNC_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .pc_i(pc_i),
    .scope_o(scope_o), .entry_o(entry_o), .exit_o(exit_o),
    .prologue_o(prologue_o), .frame_sp_o(frame_sp_o)
);

// File: tb/tb_fscope_tracker.sv
// Directed bench for the function scope detector.
module tb_fscope_tracker;
    localparam logic [31:0] FUNC = 32'h8000_0378;
    localparam logic [31:0] IDLE = 32'h8000_0100;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] pc_i;
    logic        wb0_en, wb1_en;
    logic [4:0]  wb0_idx, wb1_idx;
    logic [31:0] wb0_data, wb1_data;
    logic        scope_o, entry_o, exit_o, prologue_o;
    logic [31:0] frame_sp_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    fscope_tracker dut (
        .clk(clk), .rst_n(rst_n), .pc_i(pc_i),
        .wb0_en(wb0_en), .wb0_idx(wb0_idx), .wb0_data(wb0_data),
        .wb1_en(wb1_en), .wb1_idx(wb1_idx), .wb1_data(wb1_data),
        .scope_o(scope_o), .entry_o(entry_o), .exit_o(exit_o),
        .prologue_o(prologue_o), .frame_sp_o(frame_sp_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One cycle: drive on the falling edge, settle to mid low phase.
    task automatic cyc(input logic [31:0] pc,
                       input logic e0 = 0, input logic [4:0] i0 = 0, input logic [31:0] d0 = 0,
                       input logic e1 = 0, input logic [4:0] i1 = 0, input logic [31:0] d1 = 0);
        @(negedge clk);
        pc_i = pc; wb0_en = e0; wb0_idx = i0; wb0_data = d0;
        wb1_en = e1; wb1_idx = i1; wb1_data = d1;
        #5;
    endtask

    task automatic setsp(input logic [31:0] v);
        cyc(IDLE, 1, 5'd29, v);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        cyc(IDLE); cyc(IDLE);
        @(negedge clk);
        rst_n = 1;
        #5;
    endtask

    task automatic test_reset();
        do_reset();
        chk("R1", "scope after reset", 32'(scope_o), 0);
        chk("R1", "exit after reset", 32'(exit_o), 0);
        chk("R1", "frame after reset", frame_sp_o, 0);
        cyc(FUNC);
        chk("R2", "entry at start address", 32'(entry_o), 1);
        cyc(FUNC + 4);
        chk("R1", "frame records cleared sp", frame_sp_o, 0);
        chk("R3", "scope after entry", 32'(scope_o), 1);
        do_reset();
        chk("R1", "scope cleared by reset", 32'(scope_o), 0);
    endtask

    task automatic test_simple();
        setsp(32'h1000);
        cyc(FUNC);
        chk("R2", "entry pulse", 32'(entry_o), 1);
        chk("R5", "no prologue before scope", 32'(prologue_o), 0);
        cyc(FUNC + 4, 1, 5'd29, 32'h0FE0);
        chk("R2", "entry one cycle", 32'(entry_o), 0);
        chk("R3", "scope high", 32'(scope_o), 1);
        chk("R3", "frame recorded", frame_sp_o, 32'h1000);
        chk("R5", "prologue at +4", 32'(prologue_o), 1);
        cyc(FUNC + 8);
        chk("R5", "prologue at +8", 32'(prologue_o), 1);
        cyc(FUNC + 12);
        chk("R5", "prologue ends at +12", 32'(prologue_o), 0);
        cyc(FUNC + 16);
        chk("R6", "no exit in body", 32'(exit_o), 0);
        cyc(FUNC + 20, 0, 0, 0, 1, 5'd29, 32'h1000);
        chk("R6", "exit waits for copy", 32'(exit_o), 0);
        cyc(FUNC + 24);
        chk("R6", "exit pulse", 32'(exit_o), 1);
        chk("R9", "scope through exit", 32'(scope_o), 1);
        chk("R9", "no entry with exit", 32'(entry_o), 0);
        cyc(IDLE);
        chk("R6", "scope falls", 32'(scope_o), 0);
        chk("R6", "exit one cycle", 32'(exit_o), 0);
    endtask

    task automatic test_not_armed();
        setsp(32'h1800);
        cyc(FUNC);
        cyc(FUNC + 4, 1, 5'd29, 32'h17F0);
        cyc(FUNC + 12);
        cyc(FUNC + 16, 1, 5'd29, 32'h1800);
        cyc(FUNC + 20);
        chk("R6", "shallow drop gives no exit", 32'(exit_o), 0);
        chk("R6", "still in scope", 32'(scope_o), 1);
        cyc(FUNC + 24, 1, 5'd29, 32'h17E0);
        cyc(FUNC + 28, 1, 5'd29, 32'h1800);
        cyc(FUNC + 32);
        chk("R6", "exit after full frame drop", 32'(exit_o), 1);
        cyc(IDLE);
    endtask

    task automatic test_recursion();
        setsp(32'h2000);
        cyc(FUNC);
        cyc(FUNC + 4, 1, 5'd29, 32'h1FE0);
        cyc(FUNC + 40);
        cyc(FUNC);
        chk("R7", "no entry on re-entry", 32'(entry_o), 0);
        chk("R7", "scope kept", 32'(scope_o), 1);
        cyc(FUNC + 4, 1, 5'd29, 32'h1FC0);
        chk("R7", "frame kept", frame_sp_o, 32'h2000);
        cyc(FUNC + 16);
        cyc(FUNC + 24, 1, 5'd29, 32'h1FE0);
        cyc(FUNC + 28);
        chk("R7", "inner return no exit", 32'(exit_o), 0);
        chk("R7", "frame still outer", frame_sp_o, 32'h2000);
        cyc(FUNC + 32, 1, 5'd29, 32'h2000);
        cyc(FUNC + 36);
        chk("R6", "outer return exit", 32'(exit_o), 1);
        cyc(IDLE);
        chk("R6", "scope closed", 32'(scope_o), 0);
    endtask

    task automatic test_never_return();
        int exits = 0;
        setsp(32'h3000);
        cyc(FUNC);
        cyc(FUNC + 4, 1, 5'd29, 32'h2FE0);
        for (int i = 0; i < 200; i++) begin
            // Writes to other registers must not move the copy (R4).
            cyc(FUNC + 16 + 32'((i % 8) * 4), 1, 5'd28, 32'h4000, 1, 5'd30, 32'h5000);
            if (exit_o) exits++;
        end
        chk("R8", "no exit pulses", 32'(exits), 0);
        chk("R8", "scope held", 32'(scope_o), 1);
        chk("R4", "other index ignored", 32'(exit_o), 0);
        do_reset();
        chk("R1", "reset ends hung scope", 32'(scope_o), 0);
    endtask

    task automatic test_port_priority();
        cyc(IDLE, 1, 5'd29, 32'h4444, 1, 5'd29, 32'h5550);
        cyc(FUNC);
        cyc(FUNC + 4);
        chk("R4", "port 1 wins", frame_sp_o, 32'h5550);
        do_reset();
        cyc(IDLE, 0, 0, 0, 1, 5'd29, 32'h6000);
        cyc(IDLE, 0, 5'd29, 32'h7777, 1, 5'd30, 32'h8888);
        cyc(FUNC);
        cyc(FUNC + 4);
        chk("R4", "disabled and foreign writes ignored", frame_sp_o, 32'h6000);
        do_reset();
        cyc(IDLE, 1, 5'd29, 32'h9000);
        cyc(FUNC);
        cyc(FUNC + 4);
        chk("R4", "port 0 alone", frame_sp_o, 32'h9000);
        do_reset();
    endtask

    initial begin
        rst_n = 0; pc_i = IDLE;
        wb0_en = 0; wb0_idx = 0; wb0_data = 0;
        wb1_en = 0; wb1_idx = 0; wb1_data = 0;
        test_reset();
        test_simple();
        test_not_armed();
        test_recursion();
        test_never_return();
        test_port_priority();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule